// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Core with Subtractive Reset

This block is a time-stepped digital core of spiking neurons. It holds a set of neurons, each with a non-negative fixed-point membrane potential. On every timestep strobe, each neuron does the following in one pass:

- It decays its membrane by a shift-based leak.
- It adds the signed weights of the input lines that carry a spike.
- When recurrence is enabled, it adds the signed weights of the core's own spikes from the step before.
- It clips the result at zero and saturates it at the largest positive value.
- It compares the result with one threshold shared by every neuron.

A neuron that fires keeps the part of its potential above the threshold: the threshold is subtracted instead of clearing the membrane.

Weights sit in two matrices held in registers:

- a fully connected feedforward matrix, from every input line to every neuron;
- an all-to-all recurrent matrix over the core's own neurons.

Both matrices load through a single-entry write port. A one-to-one mode routes input line k only to neuron k, which makes the core a per-channel stage behind a bank of signal filters. Spikes and membrane values update on the clock edge that samples the strobe, and a done pulse follows each step.

Top module: `lif_core`

## Requirements
- R1: One threshold input `thresh_i` applies to every neuron. A neuron spikes in a step exactly when its clipped and saturated potential is greater than or equal to `thresh_i`.
- R2: A neuron that spikes stores its potential minus `thresh_i`, so any residue above the threshold is kept for the next step. A neuron that does not spike stores the potential unchanged.
- R3: If the leaked potential plus all weighted contributions is negative, the stored membrane is 0. No membrane is ever negative.
- R4: If that sum exceeds 2^(V_WID-1)-1, it is saturated to that value before the threshold compare. It never wraps.
- R5: When `leak_shift_i` = s, the leak runs first in the step and gives v - (v >> s). When s = 0 the leak is disabled and the membrane passes through unchanged.
- R6: Each input line j with `spk_in_i[j]`=1 adds the feedforward weight at row i, column j to neuron i. Weights are signed 8-bit two's complement.
- R7: When `rec_en_i`=1, each neuron j that spiked in the previous step adds the recurrent weight at row i, column j to neuron i. When `rec_en_i`=0, previous spikes have no effect.
- R8: When `diag_en_i`=1, neuron i receives only input line i, through feedforward weight (i,i). All other feedforward weights are ignored.
- R9: `spk_o`, `vmem_o` and `done_o` update at the clock edge that samples `step_i`=1. `done_o` is high for exactly the cycles that follow a sampled step. Between steps, `spk_o` and `vmem_o` hold their values.
- R10: A write with `wr_en_i`=1 stores `wr_data_i` at (`wr_row_i`, `wr_col_i`). `wr_bank_i`=0 selects the feedforward matrix and 1 selects the recurrent matrix. The row is the target neuron and the column is the source. A write never changes the membranes or the spikes, and a step in the same cycle uses the old weight.
- R11: A synchronous active-low reset clears every membrane, every spike (including the previous-step vector), `done_o` and every weight to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_i | input | 1 | Timestep strobe; each sampled high cycle is one step |
| spk_in_i | input | N_IN | Input spike vector for this step |
| rec_en_i | input | 1 | Enables recurrent contributions |
| diag_en_i | input | 1 | One-to-one input mode |
| thresh_i | input | V_WID-1 | Global firing threshold (unsigned) |
| leak_shift_i | input | 4 | Leak shift amount; 0 disables the leak |
| wr_en_i | input | 1 | Weight write enable |
| wr_bank_i | input | 1 | 0 = feedforward matrix, 1 = recurrent matrix |
| wr_row_i | input | ROW_AW | Target neuron index |
| wr_col_i | input | COL_AW | Source index (input line or neuron) |
| wr_data_i | input | W_WID | Signed weight value |
| spk_o | output | N_NEUR | Output spikes of the last step |
| vmem_o | output | N_NEUR*V_WID | Membranes; neuron i at bits [i*V_WID +: V_WID] |
| done_o | output | 1 | High in the cycle after a sampled step |

## Verification
A wrong membrane has no outward sign in the step where it goes wrong if it stays under the threshold. It does appear on `vmem_o` in the very next cycle, which is why the bench compares every membrane on every clock. A corrupted weight or a stale previous-spike vector changes nothing until a step uses it, and through recurrence it can then spread to other neurons a step later. The stimulus therefore steps the core repeatedly in each mode, so that any such error reaches the outputs within one step of the point where it arises.

// File: rtl/lif_pkg.sv
// Shared definitions for the neuron core.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lif_pkg;
    localparam int LEAK_SHIFT_W = 4;

    typedef enum logic {
        BANK_FF  = 1'b0,
        BANK_REC = 1'b1
    } bank_sel_e;
endpackage

// File: rtl/lif_weight_bank.sv
// Register matrix of signed weights, ROWS x COLS, with a single-entry write
// port. Reads are parallel: every row is presented as one packed vector.
// Assumes addresses outside the matrix are to be ignored.
module lif_weight_bank #(
    parameter int ROWS   = 16,
    parameter int COLS   = 16,
    parameter int W_WID  = 8,
    parameter int ROW_AW = 4,
    parameter int COL_AW = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we_i,
    input  logic [ROW_AW-1:0]        row_i,
    input  logic [COL_AW-1:0]        col_i,
    input  logic [W_WID-1:0]         data_i,
    output logic [COLS*W_WID-1:0]    rows_o [ROWS]
);
    logic [W_WID-1:0] mem_q [ROWS][COLS];

    // Stores one entry per write; reset clears the matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    mem_q[r][c] <= '0;
                end
            end
        end else if (we_i) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int c = 0; c < COLS; c++) begin
                    if (row_i == ROW_AW'(r) && col_i == COL_AW'(c)) begin
                        mem_q[r][c] <= data_i;
                    end
                end
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign rows_o[r][c*W_WID +: W_WID] = mem_q[r][c];
        end
    end
endmodule

// File: rtl/lif_syn_sum.sv
// Combinational sum of the signed weights whose source line is active.
// Assumes S_WID is wide enough for N_SRC full-scale weights.
module lif_syn_sum #(
    parameter int N_SRC = 16,
    parameter int W_WID = 8,
    parameter int S_WID = 14
) (
    input  logic [N_SRC-1:0]         act_i,
    input  logic [N_SRC*W_WID-1:0]   w_i,
    output logic signed [S_WID-1:0]  sum_o
);
    // Accumulates sign-extended weights of active sources.
    always_comb begin
        sum_o = '0;
        for (int j = 0; j < N_SRC; j++) begin
            if (act_i[j]) begin
                sum_o = sum_o + {{(S_WID-W_WID){w_i[j*W_WID+W_WID-1]}},
                                 w_i[j*W_WID +: W_WID]};
            end
        end
    end
endmodule

// File: rtl/lif_neuron.sv
// One leaky integrate-and-fire neuron. Per step: leak by shift, add
// feedforward and optional recurrent sums, clip at zero, saturate at the
// largest positive value, compare with the global threshold, and subtract
// the threshold on a spike. Assumes the membrane is held non-negative.
module lif_neuron
    import lif_pkg::*;
#(
    parameter int IDX    = 0,
    parameter int N_IN   = 16,
    parameter int N_NEUR = 16,
    parameter int W_WID  = 8,
    parameter int V_WID  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_i,
    input  logic [N_IN-1:0]           in_spk_i,
    input  logic [N_NEUR-1:0]         prev_spk_i,
    input  logic                      diag_en_i,
    input  logic                      rec_en_i,
    input  logic [V_WID-2:0]          thresh_i,
    input  logic [LEAK_SHIFT_W-1:0]   shift_i,
    input  logic [N_IN*W_WID-1:0]     ff_w_i,
    input  logic [N_NEUR*W_WID-1:0]   rec_w_i,
    output logic                      spk_o,
    output logic [V_WID-1:0]          vmem_o
);
    localparam int S_WID = W_WID + $clog2(N_IN + N_NEUR) + 1;
    localparam int ACC_W = V_WID + S_WID;
    localparam logic signed [ACC_W-1:0] VMAX_A =
        {{(ACC_W-V_WID+1){1'b0}}, {(V_WID-1){1'b1}}};

    logic [V_WID-1:0]         vmem_q;
    logic                     spk_q;
    logic [N_IN-1:0]          ff_act;
    logic signed [S_WID-1:0]  ff_sum;
    logic signed [S_WID-1:0]  rec_sum;
    logic [V_WID-1:0]         leaked;
    logic signed [ACC_W-1:0]  a_leak, a_ff, a_rec, acc;
    logic [V_WID-1:0]         clipped;
    logic                     fire;
    logic [V_WID-1:0]         vnext;

    // Masks inputs in one-to-one mode so only the own line passes.
    always_comb begin
        for (int j = 0; j < N_IN; j++) begin
            ff_act[j] = in_spk_i[j] & (!diag_en_i || j == IDX);
        end
    end

    lif_syn_sum #(.N_SRC(N_IN), .W_WID(W_WID), .S_WID(S_WID)) u_ff_sum (
        .act_i (ff_act),
        .w_i   (ff_w_i),
        .sum_o (ff_sum)
    );

    lif_syn_sum #(.N_SRC(N_NEUR), .W_WID(W_WID), .S_WID(S_WID)) u_rec_sum (
        .act_i (prev_spk_i),
        .w_i   (rec_w_i),
        .sum_o (rec_sum)
    );

    // Applies the shift leak; a zero shift leaves the membrane intact.
    always_comb begin
        if (shift_i == '0) begin
            leaked = vmem_q;
        end else begin
            leaked = vmem_q - (vmem_q >> shift_i);
        end
    end

    // Integrates, clips at zero, saturates, then fires and subtracts.
    always_comb begin
        a_leak = {{(ACC_W-V_WID){1'b0}}, leaked};
        a_ff   = {{(ACC_W-S_WID){ff_sum[S_WID-1]}}, ff_sum};
        a_rec  = rec_en_i ? {{(ACC_W-S_WID){rec_sum[S_WID-1]}}, rec_sum} : '0;
        acc    = a_leak + a_ff + a_rec;
        if (acc < 0) begin
            clipped = '0;
        end else if (acc > VMAX_A) begin
            clipped = VMAX_A[V_WID-1:0];
        end else begin
            clipped = acc[V_WID-1:0];
        end
        fire  = (clipped >= {1'b0, thresh_i});
        vnext = fire ? (clipped - {1'b0, thresh_i}) : clipped;
    end

    // Commits membrane and spike on a step; reset clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vmem_q <= '0;
            spk_q  <= 1'b0;
        end else if (step_i) begin
            vmem_q <= vnext;
            spk_q  <= fire;
        end
    end

    assign spk_o  = spk_q;
    assign vmem_o = vmem_q;
endmodule

// File: rtl/lif_core.sv
// Neuron core top: two weight matrices and N_NEUR neurons updated in
// parallel on each step strobe. The registered spike vector doubles as the
// previous-step vector for recurrence. Assumes N_IN, N_NEUR >= 2.
module lif_core
    import lif_pkg::*;
#(
    parameter int N_IN   = 16,
    parameter int N_NEUR = 16,
    parameter int W_WID  = 8,
    parameter int V_WID  = 16,
    localparam int ROW_AW = $clog2(N_NEUR),
    localparam int COL_AW = $clog2((N_IN > N_NEUR) ? N_IN : N_NEUR)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_i,
    input  logic [N_IN-1:0]           spk_in_i,
    input  logic                      rec_en_i,
    input  logic                      diag_en_i,
    input  logic [V_WID-2:0]          thresh_i,
    input  logic [LEAK_SHIFT_W-1:0]   leak_shift_i,
    input  logic                      wr_en_i,
    input  logic                      wr_bank_i,
    input  logic [ROW_AW-1:0]         wr_row_i,
    input  logic [COL_AW-1:0]         wr_col_i,
    input  logic [W_WID-1:0]          wr_data_i,
    output logic [N_NEUR-1:0]         spk_o,
    output logic [N_NEUR*V_WID-1:0]   vmem_o,
    output logic                      done_o
);
    logic [N_IN*W_WID-1:0]   ff_rows  [N_NEUR];
    logic [N_NEUR*W_WID-1:0] rec_rows [N_NEUR];
    logic                    ff_we, rec_we;
    logic                    done_q;

    assign ff_we  = wr_en_i && (bank_sel_e'(wr_bank_i) == BANK_FF);
    assign rec_we = wr_en_i && (bank_sel_e'(wr_bank_i) == BANK_REC);

    lif_weight_bank #(
        .ROWS(N_NEUR), .COLS(N_IN), .W_WID(W_WID),
        .ROW_AW(ROW_AW), .COL_AW(COL_AW)
    ) u_ff_bank (
        .clk(clk), .rst_n(rst_n), .we_i(ff_we),
        .row_i(wr_row_i), .col_i(wr_col_i), .data_i(wr_data_i),
        .rows_o(ff_rows)
    );

    lif_weight_bank #(
        .ROWS(N_NEUR), .COLS(N_NEUR), .W_WID(W_WID),
        .ROW_AW(ROW_AW), .COL_AW(COL_AW)
    ) u_rec_bank (
        .clk(clk), .rst_n(rst_n), .we_i(rec_we),
        .row_i(wr_row_i), .col_i(wr_col_i), .data_i(wr_data_i),
        .rows_o(rec_rows)
    );

    for (genvar i = 0; i < N_NEUR; i++) begin : g_neur
        lif_neuron #(
            .IDX(i), .N_IN(N_IN), .N_NEUR(N_NEUR),
            .W_WID(W_WID), .V_WID(V_WID)
        ) u_neuron (
            .clk        (clk),
            .rst_n      (rst_n),
            .step_i     (step_i),
            .in_spk_i   (spk_in_i),
            .prev_spk_i (spk_o),
            .diag_en_i  (diag_en_i),
            .rec_en_i   (rec_en_i),
            .thresh_i   (thresh_i),
            .shift_i    (leak_shift_i),
            .ff_w_i     (ff_rows[i]),
            .rec_w_i    (rec_rows[i]),
            .spk_o      (spk_o[i]),
            .vmem_o     (vmem_o[i*V_WID +: V_WID])
        );
    end

    // Marks the cycle after each sampled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= step_i;
        end
    end

    assign done_o = done_q;
endmodule

// File: rtl/lif_core_chk.sv
// Property checker for lif_core, bound to every instance of it.
// Assumes only the top-level ports are visible.
module lif_core_chk #(
    parameter int N_NEUR = 16,
    parameter int V_WID  = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    step_i,
    input logic [N_NEUR-1:0]       spk_o,
    input logic [N_NEUR*V_WID-1:0] vmem_o,
    input logic                    done_o
);
    AST_DONE_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |=> done_o); // R9

    AST_DONE_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(step_i)); // R9

    AST_HOLD_BETWEEN_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> ($stable(spk_o) && $stable(vmem_o))); // R9

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (spk_o == '0 && vmem_o == '0 && !done_o)); // R11

    for (genvar i = 0; i < N_NEUR; i++) begin : g_sign
        AST_MEMBRANE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
            vmem_o[i*V_WID + V_WID - 1] == 1'b0); // R3
    end
endmodule

bind lif_core lif_core_chk #(.N_NEUR(N_NEUR), .V_WID(V_WID)) i_lif_core_chk (
    .clk(clk), .rst_n(rst_n), .step_i(step_i),
    .spk_o(spk_o), .vmem_o(vmem_o), .done_o(done_o)
);

// File: tb/test_lif_core.sv
module test_lif_core;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 16;
    localparam int NN = 16;
    localparam int WW = 8;
    localparam int VW = 16;
    localparam int VMAX = (1 << (VW - 1)) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            step_i = 1'b0;
    logic [NI-1:0]   spk_in_i = '0;
    logic            rec_en_i = 1'b0;
    logic            diag_en_i = 1'b0;
    logic [VW-2:0]   thresh_i = '0;
    logic [3:0]      leak_shift_i = '0;
    logic            wr_en_i = 1'b0;
    logic            wr_bank_i = 1'b0;
    logic [3:0]      wr_row_i = '0;
    logic [3:0]      wr_col_i = '0;
    logic [WW-1:0]   wr_data_i = '0;
    logic [NN-1:0]   spk_o;
    logic [NN*VW-1:0] vmem_o;
    logic            done_o;

    int checks = 0;
    int errors = 0;
    string cur_req = "R11";

    // Reference state
    int ffw [NN][NI];
    int rw  [NN][NN];
    int rv  [NN];
    bit rs  [NN];
    bit rdone;

    lif_core #(.N_IN(NI), .N_NEUR(NN), .W_WID(WW), .V_WID(VW)) i_lif_core (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .spk_in_i(spk_in_i),
        .rec_en_i(rec_en_i), .diag_en_i(diag_en_i), .thresh_i(thresh_i),
        .leak_shift_i(leak_shift_i), .wr_en_i(wr_en_i), .wr_bank_i(wr_bank_i),
        .wr_row_i(wr_row_i), .wr_col_i(wr_col_i), .wr_data_i(wr_data_i),
        .spk_o(spk_o), .vmem_o(vmem_o), .done_o(done_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference: updates at each rising edge from the stable inputs.
    always @(posedge clk) begin
        int nv [NN];
        bit ns [NN];
        if (!rst_n) begin
            for (int i = 0; i < NN; i++) begin
                rv[i] = 0; rs[i] = 0;
                for (int j = 0; j < NI; j++) ffw[i][j] = 0;
                for (int j = 0; j < NN; j++) rw[i][j] = 0;
            end
            rdone = 0;
        end else begin
            if (step_i) begin
                for (int i = 0; i < NN; i++) begin
                    int a;
                    a = (leak_shift_i == 0) ? rv[i] : rv[i] - (rv[i] >> leak_shift_i);
                    for (int j = 0; j < NI; j++)
                        if (spk_in_i[j] && (!diag_en_i || i == j)) a += ffw[i][j];
                    if (rec_en_i)
                        for (int j = 0; j < NN; j++)
                            if (rs[j]) a += rw[i][j];
                    if (a < 0) a = 0;
                    if (a > VMAX) a = VMAX;
                    ns[i] = (a >= int'(thresh_i));
                    nv[i] = ns[i] ? a - int'(thresh_i) : a;
                end
                for (int i = 0; i < NN; i++) begin
                    rv[i] = nv[i]; rs[i] = ns[i];
                end
            end
            rdone = step_i;
            if (wr_en_i) begin
                if (wr_bank_i) rw[wr_row_i][wr_col_i] = int'($signed(wr_data_i));
                else           ffw[wr_row_i][wr_col_i] = int'($signed(wr_data_i));
            end
        end
    end

    // Compares outputs against the reference on every falling edge.
    always @(negedge clk) begin
        logic [NN-1:0]    es;
        logic [NN*VW-1:0] ev;
        for (int i = 0; i < NN; i++) begin
            es[i] = rs[i];
            ev[i*VW +: VW] = VW'(rv[i]);
        end
        checks += 3;
        if (spk_o !== es) begin
            errors++;
            $display("FAIL %s spikes: got %h expected %h at %0t", cur_req, spk_o, es, $time);
        end
        if (vmem_o !== ev) begin
            errors++;
            $display("FAIL %s membranes: got %h expected %h at %0t", cur_req, vmem_o, ev, $time);
        end
        if (done_o !== rdone) begin
            errors++;
            $display("FAIL R9 done: got %b expected %b at %0t", done_o, rdone, $time);
        end
    end

    task automatic wr(input bit bank, input int row, input int col, input int val);
        wr_en_i = 1'b1; wr_bank_i = bank;
        wr_row_i = 4'(row); wr_col_i = 4'(col); wr_data_i = WW'(val);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic step(input logic [NI-1:0] s);
        step_i = 1'b1; spk_in_i = s;
        @(negedge clk);
        step_i = 1'b0; spk_in_i = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fill(input bit bank, input int seed);
        for (int r = 0; r < NN; r++)
            for (int c = 0; c < 16; c++)
                wr(bank, r, c, ((r * 7 + c * 13 + seed) % 61) - 25);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        cur_req = "R11";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        cur_req = "R10";
        fill(1'b0, 3);
        idle(2);

        cur_req = "R6";
        thresh_i = 15'd60;
        step(16'hFFFF);
        step(16'h00F0);
        step(16'hA5A5);

        cur_req = "R1";
        thresh_i = 15'd20;
        step(16'h0001);
        idle(2);
        step(16'h0F0F);

        cur_req = "R2";
        thresh_i = 15'd7;
        repeat (4) step(16'hFFFF);

        cur_req = "R9";
        step_i = 1'b1; spk_in_i = 16'h3333;
        idle(3);
        step_i = 1'b0; spk_in_i = '0;
        idle(3);

        cur_req = "R3";
        thresh_i = 15'd500;
        for (int c = 0; c < NI; c++) wr(1'b0, 0, c, -100);
        step(16'hFFFF);
        step(16'h0101);

        cur_req = "R5";
        for (int c = 0; c < NI; c++) wr(1'b0, 1, c, 120);
        step(16'hFFFF);
        leak_shift_i = 4'd2;
        repeat (3) step(16'h0000);
        leak_shift_i = 4'd1;
        step(16'h0002);
        leak_shift_i = 4'd0;
        step(16'h0000);

        cur_req = "R4";
        thresh_i = 15'(VMAX);
        for (int r = 0; r < NN; r++) wr(1'b0, r, r, 127);
        for (int c = 0; c < NI; c++) wr(1'b0, 2, c, 127);
        repeat (20) step(16'hFFFF);

        cur_req = "R10";
        thresh_i = 15'd40;
        wr_en_i = 1'b1; wr_bank_i = 1'b0; wr_row_i = 4'd5; wr_col_i = 4'd5; wr_data_i = 8'sd90;
        step_i = 1'b1; spk_in_i = 16'h0020;
        @(negedge clk);
        wr_en_i = 1'b0; step_i = 1'b0; spk_in_i = '0;
        step(16'h0020);

        cur_req = "R8";
        diag_en_i = 1'b1;
        thresh_i = 15'd30;
        step(16'hFFFF);
        step(16'h00FF);
        step(16'hFF00);
        diag_en_i = 1'b0;

        cur_req = "R7";
        fill(1'b1, 11);
        thresh_i = 15'd25;
        rec_en_i = 1'b0;
        step(16'hFFFF);
        step(16'h0000);
        rec_en_i = 1'b1;
        step(16'hFFFF);
        repeat (4) step(16'h0000);
        rec_en_i = 1'b0;

        cur_req = "R1";
        rec_en_i = 1'b1;
        leak_shift_i = 4'd3;
        thresh_i = 15'd150;
        for (int k = 0; k < 200; k++) begin
            if (k % 50 == 0) wr(k[0], $urandom % NN, $urandom % NN, int'($urandom % 256) - 128);
            diag_en_i = (k % 37 == 0);
            step(NI'($urandom));
            if (k % 9 == 0) idle(1);
        end
        diag_en_i = 1'b0;

        cur_req = "R11";
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        step(16'hFFFF);
        idle(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule